// File: doc/BRIEF.md
# I2C Stuck-Bus Fault Generator

This block is a bit-level I2C master that drives an open-drain SCL/SDA pair. It is attached to a second I2C bus so that it can leave that bus in deliberately broken states. Another master on the same bus can then be tested against those states. Two manual controls pull either wire low or let it go, and two synchronized level outputs report what each wire actually carries. The level seen on each wire is the wired-AND of this block's drive and everything else on the bus.

Two one-shot commands each take a 7-bit target address. The address-read command sends a START and the address with the read bit set. It then raises SCL for the acknowledge bit and stops there. The write-byte command sends the address with the write bit clear, clocks through the address acknowledge, then sends a 0x00 data byte. It stops with SCL high in the acknowledge slot of that byte. In both cases the addressed device is left holding SDA low, and this block produces no further SCL pulses and no STOP. A manual write that releases both wires brings the block back to idle.

Top module: `i2c_stuck_bus_gen`

## Requirements
- R1: After reset both drive outputs are 0 (wires released), and `busy` and `halted` are both 0.
- R2: A manual write with `man_scl_rel`=0 sets `scl_drive_low` to 1 from the next clock, and one with `man_scl_rel`=1 clears it. `sda_drive_low` is not affected by this field.
- R3: A manual write with `man_sda_rel`=0 sets `sda_drive_low` to 1 from the next clock, and one with `man_sda_rel`=1 clears it. `scl_drive_low` is not affected by this field.
- R4: `scl_level` and `sda_level` follow `scl_in` and `sda_in` with a delay of SYNC_STAGES clocks (default 2). They read 1 after reset.
- R5: With `cmd_wr`=0, the command makes exactly one START (SDA falls while SCL is high). It then sends `{addr,1}` MSB first, one bit per SCL rise, with SDA changing only while SCL is low. The 9th SCL rise is the last one.
- R6: With `cmd_wr`=1, the command sends one START and then `{addr,0}`. After the address acknowledge it sends the byte 0x00. There are 18 SCL rises in all, the 18th being the acknowledge of the data byte.
- R7: Once halted, the block releases both wires and makes no further SCL edge and no STOP, so SCL stays high and an acknowledging device keeps SDA low.
- R8: `busy` is 1 from the clock that samples `cmd_valid`. `halted` rises, and `busy` falls, exactly 2·N·HALF clocks after that clock, where N is 9 for an address-read and 18 for a write-byte.
- R9: `cmd_valid` is ignored while `busy` is 1; the running transfer is unchanged.
- R10: `cmd_valid` is ignored while `halted` is 1: `busy` stays 0 and SCL does not toggle.
- R11: From the halted state, a manual write with both release fields at 1 returns the block to idle on the next clock. A manual write that keeps either wire forced leaves it halted.
- R12: Every SCL phase lasts HALF = SYS_HZ/(2·BUS_HZ) clocks, so consecutive SCL rises are 2·HALF clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the SCL bus wire |
| sda_in | input | 1 | Sensed level of the SDA bus wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| man_wr | input | 1 | Strobe that loads both manual wire controls |
| man_scl_rel | input | 1 | Manual SCL control: 0 force low, 1 release |
| man_sda_rel | input | 1 | Manual SDA control: 0 force low, 1 release |
| cmd_valid | input | 1 | Starts a command when the block is idle |
| cmd_wr | input | 1 | 0 selects address-read, 1 selects write-byte |
| cmd_addr | input | 7 | 7-bit target address |
| scl_level | output | 1 | Synchronized SCL level |
| sda_level | output | 1 | Synchronized SDA level |
| busy | output | 1 | A command is in progress |
| halted | output | 1 | Stopped in an acknowledge slot with SCL high |

## Verification
Manual drive changes are due one clock after the strobe, and level readback is due SYNC_STAGES clocks after the bus wire moves. The bench samples both on the falling clock edge after exactly that many rising edges, and it also checks the cycle before to confirm the readback is not early. For each command it counts rising edges from the sampling edge until `halted` is seen and compares the count with 1 + 2·N·HALF; it checks `busy` on the first of those edges. Bit content and SCL spacing come from a bus monitor that samples SDA on each SCL rise. The monitor times the rises with a free-running cycle counter, so the checks do not depend on the order of processes within a clock edge.

// File: rtl/i2c_sbg_pkg.sv
package i2c_sbg_pkg;

  localparam int FRAME_W = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_HALT
  } seq_state_e;

  // Clocks per SCL phase (low or high) for a given system and bus rate.
  function automatic int half_cycles(int sys_hz, int bus_hz);
    return sys_hz / (2 * bus_hz);
  endfunction

  // SDA value for each SCL pulse, MSB sent first; a 1 means "released".
  // Acknowledge slots are released so that the target can pull them.
  function automatic logic [FRAME_W-1:0] build_frame(logic wr, logic [6:0] a);
    if (wr) return {a, 1'b0, 1'b1, 8'h00, 1'b1};
    return {a, 1'b1, 1'b1, 9'h000};
  endfunction

  // Number of SCL pulses before the halt point.
  function automatic logic [4:0] frame_bits(logic wr);
    return wr ? 5'd18 : 5'd9;
  endfunction

endpackage

// File: rtl/i2c_sbg_sync.sv
module i2c_sbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r_q <= 1'b1;
        else        r_q <= d;
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      assign q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_sbg_divider.sv
module i2c_sbg_divider #(
  parameter int HALF = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick,
  output logic first
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick  = (cnt_q == LAST);
  assign first = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;

  // R12: a phase never runs past HALF clocks
  assert_phase_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/i2c_sbg_seq.sv
module i2c_sbg_seq
  import i2c_sbg_pkg::*;
#(
  parameter int HALF = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_wr,
  input  logic [6:0] cmd_addr,
  input  logic       release_all,
  input  logic       tick,
  input  logic       first,
  output logic       restart,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       halted
);

  seq_state_e         state;
  logic [FRAME_W-1:0] frame_q;
  logic [4:0]         idx_q;
  logic [4:0]         nbits_q;
  logic               scl_low_q;
  logic               sda_low_q;

  // Named internal events for the assertions
  logic last_bit;
  logic in_high;

  assign last_bit = (idx_q == nbits_q - 5'd1);
  assign in_high  = (state == ST_HIGH);

  assign busy    = (state == ST_START) || (state == ST_LOW) || in_high;
  assign halted  = (state == ST_HALT);
  assign restart = (state == ST_IDLE) || halted;
  assign scl_low = scl_low_q;
  assign sda_low = sda_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      frame_q   <= '0;
      idx_q     <= '0;
      nbits_q   <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          frame_q   <= build_frame(cmd_wr, cmd_addr);
          nbits_q   <= frame_bits(cmd_wr);
          idx_q     <= '0;
          sda_low_q <= 1'b1;            // START: SDA falls, SCL high
          state     <= ST_START;
        end
        ST_START: if (tick) begin
          scl_low_q <= 1'b1;
          state     <= ST_LOW;
        end
        ST_LOW: begin
          // SDA moves one clock after SCL has fallen
          if (first) sda_low_q <= ~frame_q[FRAME_W-1];
          if (tick) begin
            scl_low_q <= 1'b0;
            state     <= last_bit ? ST_HALT : ST_HIGH;
          end
        end
        ST_HIGH: if (tick) begin
          scl_low_q <= 1'b1;
          frame_q   <= {frame_q[FRAME_W-2:0], 1'b0};
          idx_q     <= idx_q + 5'd1;
          state     <= ST_LOW;
        end
        ST_HALT: if (release_all) begin
          scl_low_q <= 1'b0;
          sda_low_q <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: data on SDA is held for the whole SCL high phase
  assert_sda_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && $past(in_high)) |-> $stable(sda_low_q));

  // R7: at the halt point neither wire is driven
  assert_halt_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!scl_low_q && !sda_low_q));

  // R9: a command during a transfer does not change its length
  assert_busy_ignores_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(nbits_q));

  // R10/R11: only a full release leaves the halt state
  assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !release_all) |=> halted);

  assert_busy_halt_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, halted}));

endmodule

// File: rtl/i2c_stuck_bus_gen.sv
module i2c_stuck_bus_gen
  import i2c_sbg_pkg::*;
#(
  parameter int SYS_HZ      = 100_000_000,
  parameter int BUS_HZ      = 100_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       man_wr,
  input  logic       man_scl_rel,
  input  logic       man_sda_rel,
  input  logic       cmd_valid,
  input  logic       cmd_wr,
  input  logic [6:0] cmd_addr,
  output logic       scl_level,
  output logic       sda_level,
  output logic       busy,
  output logic       halted
);

  localparam int HALF = half_cycles(SYS_HZ, BUS_HZ);

  logic force_scl_q, force_sda_q;
  logic release_all;
  logic tick, first, restart;
  logic seq_scl_low, seq_sda_low;

  assign release_all = man_wr && man_scl_rel && man_sda_rel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      force_scl_q <= 1'b0;
      force_sda_q <= 1'b0;
    end else if (man_wr) begin
      force_scl_q <= ~man_scl_rel;
      force_sda_q <= ~man_sda_rel;
    end

  i2c_sbg_divider #(.HALF(HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .first   (first)
  );

  i2c_sbg_seq #(.HALF(HALF)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_wr      (cmd_wr),
    .cmd_addr    (cmd_addr),
    .release_all (release_all),
    .tick        (tick),
    .first       (first),
    .restart     (restart),
    .scl_low     (seq_scl_low),
    .sda_low     (seq_sda_low),
    .busy        (busy),
    .halted      (halted)
  );

  i2c_sbg_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk (clk), .rst_n (rst_n), .d (scl_in), .q (scl_level)
  );

  i2c_sbg_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk (clk), .rst_n (rst_n), .d (sda_in), .q (sda_level)
  );

  assign scl_drive_low = force_scl_q | seq_scl_low;
  assign sda_drive_low = force_sda_q | seq_sda_low;

  // R2: manual SCL force reaches the pin on the next clock
  assert_man_scl_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (man_wr && !man_scl_rel) |=> scl_drive_low);

  // R3: manual SDA force reaches the pin on the next clock
  assert_man_sda_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (man_wr && !man_sda_rel) |=> sda_drive_low);

  // R7: a halted block with no manual force leaves SCL released
  assert_halt_scl_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !force_scl_q) |-> !scl_drive_low);

endmodule

// File: tb/tb_i2c_stuck_bus_gen.sv
`timescale 1ns/1ps
module tb_i2c_stuck_bus_gen;

  localparam int SYS = 250_000_000;
  localparam int BUS = 5_000_000;
  localparam int HALF_EXP = SYS / (2 * BUS);   // 25 clocks per SCL phase

  // {wr, addr[6:0], exp_byte0, exp_byte1, exp_rises}
  localparam logic [31:0] VEC [4] = '{
    {1'b0, 7'h50, 8'hA1, 8'h00, 8'd9},
    {1'b1, 7'h3F, 8'h7E, 8'h00, 8'd18},
    {1'b0, 7'h7F, 8'hFF, 8'h00, 8'd9},
    {1'b1, 7'h01, 8'h02, 8'h00, 8'd18}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic man_wr = 1'b0, man_scl_rel = 1'b1, man_sda_rel = 1'b1;
  logic cmd_valid = 1'b0, cmd_wr = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic tb_scl_pull = 1'b0, tb_sda_pull = 1'b0, slave_pull = 1'b0;
  logic scl_drive_low, sda_drive_low, scl_level, sda_level, busy, halted;
  wire  scl_bus = ~(scl_drive_low | tb_scl_pull);
  wire  sda_bus = ~(sda_drive_low | tb_sda_pull | slave_pull);

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_stuck_bus_gen #(.SYS_HZ(SYS), .BUS_HZ(BUS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .man_wr(man_wr), .man_scl_rel(man_scl_rel), .man_sda_rel(man_sda_rel),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .scl_level(scl_level), .sda_level(sda_level), .busy(busy), .halted(halted)
  );

  // ---------------- bus monitor and acknowledging target ----------------
  int cyc = 0;
  int starts = 0, stops = 0, rises = 0, bitcnt = 0, byteidx = 0;
  int last_rise = 0, prev_rise = 0;
  logic [7:0] shreg = '0, b0 = '0, b1 = '0;
  logic [6:0] slave_addr = '0;

  always @(posedge clk) cyc++;

  always @(negedge sda_bus) if (scl_bus === 1'b1) begin
    starts++; bitcnt = 0; byteidx = 0;
  end
  always @(posedge sda_bus) if (scl_bus === 1'b1) stops++;

  always @(posedge scl_bus) begin
    rises++;
    prev_rise = last_rise; last_rise = cyc;
    if (bitcnt < 8) shreg = {shreg[6:0], sda_bus};
    bitcnt++;
    if (bitcnt == 8) begin
      if (byteidx == 0) b0 = shreg;
      else if (byteidx == 1) b1 = shreg;
    end
    if (bitcnt == 9) begin bitcnt = 0; byteidx++; end
  end

  always @(negedge scl_bus)
    slave_pull = (bitcnt == 8) && (byteidx != 0 || shreg[7:1] == slave_addr);

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic man_write(input logic scl_rel, input logic sda_rel);
    @(negedge clk);
    man_wr = 1'b1; man_scl_rel = scl_rel; man_sda_rel = sda_rel;
    @(negedge clk);
    man_wr = 1'b0; man_scl_rel = 1'b1; man_sda_rel = 1'b1;
  endtask

  task automatic clear_monitor();
    slave_pull = 1'b0;
    #1;
    starts = 0; stops = 0; rises = 0; bitcnt = 0; byteidx = 0;
    b0 = '0; b1 = '0; shreg = '0;
  endtask

  // Issue a command and count rising edges until halted (sampling edge = 1).
  task automatic run_cmd(input logic wr, input logic [6:0] a, output int ncyc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = wr; cmd_addr = a;
    ncyc = 0;
    do begin
      @(posedge clk); ncyc++;
      @(negedge clk);
      if (ncyc == 1) begin
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R8 busy after sample", busy, 1);
      end
    end while (halted !== 1'b1 && ncyc < 5000);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    int r0;
    repeat (5) @(negedge clk);
    check(scl_drive_low === 1'b0 && sda_drive_low === 1'b0, "R1 drives", {scl_drive_low, sda_drive_low}, 0);
    check(busy === 1'b0 && halted === 1'b0, "R1 flags", {busy, halted}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(scl_level === 1'b1 && sda_level === 1'b1, "R4 idle levels", {scl_level, sda_level}, 3);

    // R2: force SCL, SDA untouched
    man_write(1'b0, 1'b1);
    check(scl_drive_low === 1'b1, "R2 scl forced", scl_drive_low, 1);
    check(sda_drive_low === 1'b0, "R2 sda independent", sda_drive_low, 0);
    // R3: release SCL, force SDA
    man_write(1'b1, 1'b0);
    check(scl_drive_low === 1'b0, "R2 scl released", scl_drive_low, 0);
    check(sda_drive_low === 1'b1, "R3 sda forced", sda_drive_low, 1);
    man_write(1'b1, 1'b1);
    check(sda_drive_low === 1'b0, "R3 sda released", sda_drive_low, 0);

    // R4: external pull seen after exactly two clocks
    repeat (3) @(negedge clk);
    tb_scl_pull = 1'b1;
    @(negedge clk);
    check(scl_level === 1'b1, "R4 not early", scl_level, 1);
    @(negedge clk);
    check(scl_level === 1'b0, "R4 scl low after 2", scl_level, 0);
    check(sda_level === 1'b1, "R4 sda unaffected", sda_level, 1);
    tb_scl_pull = 1'b0;
    repeat (3) @(negedge clk);
    clear_monitor();

    // ---- table of commands ----
    for (int i = 0; i < 4; i++) begin
      logic wr;
      logic [6:0] a;
      int nb;
      wr = VEC[i][31]; a = VEC[i][30:24]; nb = int'(VEC[i][7:0]);
      slave_addr = a;
      clear_monitor();
      run_cmd(wr, a, n);
      check(n == 1 + 2 * nb * HALF_EXP, "R8 halt latency", n, 1 + 2 * nb * HALF_EXP);
      check(busy === 1'b0 && halted === 1'b1, "R8 flags at halt", {busy, halted}, 1);
      check(starts == 1, "R5 one START", starts, 1);
      check(b0 == VEC[i][23:16], wr ? "R6 address byte" : "R5 address byte", b0, VEC[i][23:16]);
      if (wr) check(b1 == VEC[i][15:8], "R6 data byte", b1, VEC[i][15:8]);
      check(rises == nb, wr ? "R6 SCL rises" : "R5 SCL rises", rises, nb);
      check(last_rise - prev_rise == 2 * HALF_EXP, "R12 SCL period", last_rise - prev_rise, 2 * HALF_EXP);
      check(scl_bus === 1'b1 && sda_bus === 1'b0, "R7 stuck bus", {scl_bus, sda_bus}, 2);
      r0 = rises;
      repeat (200) @(negedge clk);
      check(rises == r0 && stops == 0, "R7 no edges no STOP", rises, r0);
      check(scl_drive_low === 1'b0 && sda_drive_low === 1'b0, "R7 released", {scl_drive_low, sda_drive_low}, 0);
      man_write(1'b1, 1'b1);
      check(halted === 1'b0 && busy === 1'b0, "R11 release to idle", {busy, halted}, 0);
      clear_monitor();
      repeat (10) @(negedge clk);
    end

    // ---- R9: command while busy is ignored ----
    slave_addr = 7'h50;
    clear_monitor();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_addr = 7'h50;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_addr = 7'h3F;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (halted !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    check(rises == 9 && b0 == 8'hA1, "R9 transfer unchanged", rises, 9);

    // ---- R10: command while halted is ignored ----
    r0 = rises;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_addr = 7'h3F;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b0 && halted === 1'b1, "R10 stays halted", {busy, halted}, 1);
    repeat (300) @(negedge clk);
    check(rises == r0, "R10 no SCL activity", rises, r0);

    // ---- R11: partial release keeps the halt ----
    man_write(1'b1, 1'b0);
    check(halted === 1'b1, "R11 partial release", halted, 1);
    man_write(1'b1, 1'b1);
    check(halted === 1'b0, "R11 full release", halted, 0);
    clear_monitor();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule